// File: doc/BRIEF.md
# Idle-aware transactional clock gate controller

This block computes the clock-enable signals for a group of transactional units and a group of peripheral clocks. Each enable goes to a glitch-free gating cell outside the block. Software controls the block through a small register port. It writes a hint vector, with one bit per transactional unit, and a peripheral enable vector, with one bit per peripheral clock. It can read back both vectors and a read-only status vector that shows the real gate state of each unit.

A unit's clock can be switched off only when software has cleared the unit's hint and the unit reports that it is idle. While a unit is busy its clock stays on, so the status vector may lag behind the hint. A power-manager enable can force clocks off: one enable covers all transactional units, and each peripheral has its own. A 4-bit scan-mode code turns every enable on and overrides all other inputs. Every enable output is registered, so it follows its inputs one clock later.

Top module: `xcg_top`

## Requirements
- R1: If a unit's hint bit is 1 and `pwr_main_en` is 1, that unit's `unit_clk_en` bit is 1 one cycle later.
- R2: If a unit's hint bit is 0, its `unit_idle` bit is 0 (busy) and `pwr_main_en` is 1, its `unit_clk_en` bit is 1 one cycle later.
- R3: If a unit's hint bit is 0, its `unit_idle` bit is 1 and scan mode is off, its `unit_clk_en` bit is 0 one cycle later.
- R4: A read of address 2 (hint status) returns the current `unit_clk_en` vector in bits [NUM_UNITS-1:0] and zero in the upper bits. For an idle unit this equals its hint bit. For a busy unit whose hint is clear it reads 1.
- R5: If `pwr_main_en` is 0 and scan mode is off, every `unit_clk_en` bit is 0 one cycle later.
- R6: Peripheral bit i of `peri_clk_en` is, one cycle later, (enable register bit i AND `pwr_peri_en[i]`) OR scan-on.
- R7: Scan mode is on only for the exact code `scan_mode == 4'b0110`. When scan mode is on, every unit and peripheral enable is 1 one cycle later. Any other code counts as off.
- R8: During reset the hint register, the peripheral enable register and both enable output vectors are all ones.
- R9: A write to address 2 or address 3 changes no register. A read of address 3 returns zero.
- R10: A write to address 0 loads the hint register from `reg_wdata[NUM_UNITS-1:0]`. A write to address 1 loads the peripheral enable register from `reg_wdata[NUM_PERI-1:0]`. A read of either address returns that register, zero-extended. Writes take effect at the clock edge where `reg_we` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 hint, 1 peripheral enable, 2 status) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| unit_idle | input | NUM_UNITS | Idle flag per transactional unit |
| pwr_main_en | input | 1 | Power-manager enable for transactional clocks |
| pwr_peri_en | input | NUM_PERI | Power-manager enable per peripheral clock |
| scan_mode | input | 4 | Multi-value scan code, on only at 4'b0110 |
| unit_clk_en | output | NUM_UNITS | Registered clock enable per unit |
| peri_clk_en | output | NUM_PERI | Registered clock enable per peripheral |

## Verification
The hardest case to reach from the ports is a unit whose hint is cleared while it is busy, which then goes idle with no further write. The clock must stop on the cycle after idle rises, and the status read must move from 1 to the hint value at the same time. The directed stimulus clears all hints while every unit is busy, holds that state for several cycles, and then raises idle on only some units. A random phase then varies hint writes, idle flags, the power enables and scan codes, including codes one bit away from the on code. A behavioural model checks every output bit on every cycle.

// File: rtl/xcg_pkg.sv
package xcg_pkg;
  localparam logic [1:0] ADDR_HINT   = 2'd0;
  localparam logic [1:0] ADDR_PERI   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [3:0] SCAN_ON_CODE = 4'b0110;

  function automatic logic scan_is_on(input logic [3:0] code);
    return code == SCAN_ON_CODE;
  endfunction
endpackage

// File: rtl/xcg_regfile.sv
module xcg_regfile #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_PERI  = 3,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NUM_UNITS-1:0] status,
  output logic [NUM_UNITS-1:0] hint_q,
  output logic [NUM_PERI-1:0]  peri_q,
  output logic [DW-1:0]        rdata
);
  import xcg_pkg::*;

  logic                 hint_wr, peri_wr;
  logic [NUM_UNITS-1:0] hint_d;
  logic [NUM_PERI-1:0]  peri_d;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata;
  assign hint_wr = we && (addr == ADDR_HINT);
  assign peri_wr = we && (addr == ADDR_PERI);

  always_comb begin
    hint_d = hint_q;
    peri_d = peri_q;
    if (hint_wr) hint_d = wdata[NUM_UNITS-1:0];
    if (peri_wr) peri_d = wdata[NUM_PERI-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hint_q <= '1;
      peri_q <= '1;
    end else begin
      hint_q <= hint_d;
      peri_q <= peri_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_HINT:   rdata[NUM_UNITS-1:0] = hint_q;
      ADDR_PERI:   rdata[NUM_PERI-1:0]  = peri_q;
      ADDR_STATUS: rdata[NUM_UNITS-1:0] = status;
      default:     rdata = '0;
    endcase
  end

  assert_locked_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[1]) |=> ($stable(hint_q) && $stable(peri_q)));

  assert_hint_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_HINT) |=> (hint_q == $past(wdata[NUM_UNITS-1:0])));

  assert_peri_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_PERI) |=> (peri_q == $past(wdata[NUM_PERI-1:0])));
endmodule

// File: rtl/xcg_unit_gate.sv
module xcg_unit_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hint,
  input  logic idle,
  input  logic pwr_en,
  input  logic scan_on,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = scan_on || (pwr_en && (hint || !idle));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assert_hint_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hint && pwr_en) |=> en_q);

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hint && !idle && pwr_en) |=> en_q);

  assert_idle_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hint && idle && !scan_on) |=> !en_q);

  assert_pwr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !scan_on) |=> !en_q);
endmodule

// File: rtl/xcg_peri_gate.sv
module xcg_peri_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic pwr_en,
  input  logic scan_on,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = scan_on || (sw_en && pwr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assert_peri_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sw_en || !pwr_en) && !scan_on) |=> !en_q);

  assert_peri_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && pwr_en) |=> en_q);
endmodule

// File: rtl/xcg_top.sv
module xcg_top #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_PERI  = 3,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NUM_UNITS-1:0] unit_idle,
  input  logic                 pwr_main_en,
  input  logic [NUM_PERI-1:0]  pwr_peri_en,
  input  logic [3:0]           scan_mode,
  output logic [NUM_UNITS-1:0] unit_clk_en,
  output logic [NUM_PERI-1:0]  peri_clk_en
);
  import xcg_pkg::*;

  logic [NUM_UNITS-1:0] hint_q;
  logic [NUM_PERI-1:0]  peri_q;
  logic                 scan_on;

  assign scan_on = scan_is_on(scan_mode);

  xcg_regfile #(.NUM_UNITS(NUM_UNITS), .NUM_PERI(NUM_PERI), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(unit_clk_en), .hint_q(hint_q), .peri_q(peri_q), .rdata(reg_rdata)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    xcg_unit_gate u_gate (
      .clk(clk), .rst_n(rst_n), .hint(hint_q[u]), .idle(unit_idle[u]),
      .pwr_en(pwr_main_en), .scan_on(scan_on), .en_q(unit_clk_en[u])
    );
  end

  for (genvar p = 0; p < NUM_PERI; p++) begin : g_peri
    xcg_peri_gate u_gate (
      .clk(clk), .rst_n(rst_n), .sw_en(peri_q[p]), .pwr_en(pwr_peri_en[p]),
      .scan_on(scan_on), .en_q(peri_clk_en[p])
    );
  end

  assert_scan_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 4'b0110) |=> (&unit_clk_en && &peri_clk_en));

  assert_scan_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode != 4'b0110 && !pwr_main_en) |=> (unit_clk_en == '0));

  assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[NUM_UNITS-1:0] == unit_clk_en));
endmodule

// File: tb/xcg_top_tb.sv
module xcg_top_tb;
  localparam int NU = 4;
  localparam int NP = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [NU-1:0] unit_idle;
  logic          pwr_main_en;
  logic [NP-1:0] pwr_peri_en;
  logic [3:0]    scan_mode;
  logic [NU-1:0] unit_clk_en;
  logic [NP-1:0] peri_clk_en;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  bit live  = 0;

  always #2 clk = ~clk;

  xcg_top #(.NUM_UNITS(NU), .NUM_PERI(NP), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .unit_idle(unit_idle),
    .pwr_main_en(pwr_main_en), .pwr_peri_en(pwr_peri_en), .scan_mode(scan_mode),
    .unit_clk_en(unit_clk_en), .peri_clk_en(peri_clk_en)
  );

  // behavioural reference state
  bit m_hint [NU];
  bit m_peri [NP];
  bit e_unit [NU];
  bit e_peri [NP];
  string cause [NU];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_hint[i]) begin m_hint[i] = 1; e_unit[i] = 1; cause[i] = "R8"; end
      foreach (m_peri[i]) begin m_peri[i] = 1; e_peri[i] = 1; end
    end else begin
      bit scan;
      scan = (scan_mode === 4'b0110);
      foreach (e_unit[i]) begin
        if (scan)               begin e_unit[i] = 1; cause[i] = "R7"; end
        else if (!pwr_main_en)  begin e_unit[i] = 0; cause[i] = "R5"; end
        else if (m_hint[i])     begin e_unit[i] = 1; cause[i] = "R1"; end
        else if (!unit_idle[i]) begin e_unit[i] = 1; cause[i] = "R2"; end
        else                    begin e_unit[i] = 0; cause[i] = "R3"; end
      end
      foreach (e_peri[i]) e_peri[i] = scan || (m_peri[i] && pwr_peri_en[i]);
      if (reg_we && reg_addr == 2'd0) foreach (m_hint[i]) m_hint[i] = reg_wdata[i];
      if (reg_we && reg_addr == 2'd1) foreach (m_peri[i]) m_peri[i] = reg_wdata[i];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input logic [1:0] a);
    int v = 0;
    case (a)
      2'd0: foreach (m_hint[i]) v |= int'(m_hint[i]) << i;
      2'd1: foreach (m_peri[i]) v |= int'(m_peri[i]) << i;
      2'd2: foreach (e_unit[i]) v |= int'(e_unit[i]) << i;
      default: v = 0;
    endcase
    return v;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      foreach (e_unit[i]) check(cause[i], int'(unit_clk_en[i]), int'(e_unit[i]));
      foreach (e_peri[i]) check(scan_mode == 4'b0110 ? "R7" : "R6",
                                int'(peri_clk_en[i]), int'(e_peri[i]));
      check(reg_addr == 2'd2 ? "R4" : (reg_addr == 2'd3 ? "R9" : "R10"),
            int'(reg_rdata), exp_rdata(reg_addr));
    end
  end

  task automatic step(input bit we, input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_we = we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) step(0, reg_addr, '0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    unit_idle = '0; pwr_main_en = 1; pwr_peri_en = '1; scan_mode = 4'b0000;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", int'(unit_clk_en), (1 << NU) - 1);
    check("R8", int'(peri_clk_en), (1 << NP) - 1);
    check("R8", int'(reg_rdata), (1 << NU) - 1);
    reg_addr = 2'd1; #0.5;
    check("R8", int'(reg_rdata), (1 << NP) - 1);
    rst_n = 1; live = 1;
    // R2: hints cleared while all units busy, clocks stay on
    step(1, 2'd0, '0);
    step(0, 2'd2, '0);
    idle_cycles(4);
    // R3 / R4: some units go idle with no further write
    unit_idle = 4'b0101;
    idle_cycles(3);
    // R1: hint set on an idle unit
    step(1, 2'd0, 8'h01);
    step(0, 2'd2, '0);
    idle_cycles(2);
    unit_idle = '1;
    idle_cycles(2);
    // R5: main power enable low
    pwr_main_en = 0;
    idle_cycles(3);
    // R7: exact code and near misses
    scan_mode = 4'b0110; idle_cycles(2);
    scan_mode = 4'b0111; idle_cycles(2);
    scan_mode = 4'b1001; idle_cycles(2);
    scan_mode = 4'b0100; idle_cycles(2);
    scan_mode = 4'b0000; pwr_main_en = 1;
    // R6: peripheral enables against power enables
    step(1, 2'd1, 8'h02);
    pwr_peri_en = 3'b011;
    step(0, 2'd1, '0);
    idle_cycles(2);
    pwr_peri_en = 3'b110;
    idle_cycles(2);
    // R9: writes to status and spare address change nothing
    step(1, 2'd2, 8'hff);
    step(1, 2'd3, 8'h00);
    step(0, 2'd0, '0);
    step(0, 2'd1, '0);
    step(0, 2'd3, '0);
    // R10: write and read back both registers
    step(1, 2'd0, 8'hfa);
    step(1, 2'd1, 8'hf5);
    step(0, 2'd0, '0);
    step(0, 2'd1, '0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      reg_we      = ($urandom % 4) == 0;
      reg_addr    = 2'($urandom);
      reg_wdata   = 8'($urandom);
      unit_idle   = NU'($urandom);
      pwr_main_en = ($urandom % 5) != 0;
      pwr_peri_en = NP'($urandom);
      case ($urandom % 8)
        0: scan_mode = 4'b0110;
        1: scan_mode = 4'b0110 ^ (4'b0001 << ($urandom % 4));
        default: scan_mode = 4'($urandom) & 4'b1001;
      endcase
    end
    @(negedge clk);
    live = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule